// File: doc/BRIEF.md
# Framebuffer Transfer Format Converter

This block copies a rectangular image from one region of memory to another and converts the pixel encoding on the way. Software programs a source base, a destination base, the source and destination sizes and a mode word, then writes a trigger. The engine then walks the destination image one pixel at a time, in row-major order. For each destination pixel it fetches one or two source pixels through a simple read port, converts them, and stores the result through a simple write port.

Each pixel occupies one 32-bit memory word, aligned to the low bits. The mode word selects the source and destination encodings from five colour layouts. It can also flip the image top to bottom, halve the width by averaging horizontal pairs, or request a raw word copy with no conversion. A tiling request bit is accepted but has no effect, so all layouts are linear. The block reports `busy_o` for the duration of a transfer and a sticky `done_o` when it finishes.

Top module: `fbx_xfer`

## Requirements
- R1: Config register index 0 holds the source base and index 1 the destination base, each written as byte address >> 3 (data bits 28:0). Pixel (x, y) of a buffer of width W lives at byte address base*8 + 4*(y*W + x), one pixel per 32-bit word.
- R2: Index 2 is the source size and index 3 the destination size: width in bits 15:0, height in bits 31:16. The destination size sets how many pixels are written. The source width sets the source row pitch.
- R3: A write to index 5 with data bit 0 set starts a transfer when the block is idle. `busy_o` is high from the next cycle until the last write. `done_o` clears at the start and is set when the transfer ends.
- R4: While `busy_o` is high, all config writes are ignored, including the trigger.
- R5: Mode word (index 4) bits 10:8 select the source format and bits 14:12 the destination format. The codes are: 0 = R[31:24] G[23:16] B[15:8] A[7:0]; 1 = R[23:16] G[15:8] B[7:0]; 2 = R[15:11] G[10:5] B[4:0]; 3 = R[15:11] G[10:6] B[5:1] A[0]; 4 = R[15:12] G[11:8] B[7:4] A[3:0]. Codes 5 to 7 behave as code 0.
- R6: Decoding widens each channel to 8 bits by repeating its high bits below it. A format with no alpha decodes alpha as 0xFF.
- R7: Encoding keeps the top bits of each 8-bit channel and drops the rest. Word bits above the format's layout are zero.
- R8: Mode bit 0 set: destination row y is taken from source row (dest height - 1 - y).
- R9: Mode bit 3 set: the source word is written unchanged with no format conversion. Mode bit 1 (tiling) is ignored, whether or not bit 3 is set.
- R10: Mode bit 24 set: destination pixel x uses source pixels 2x and 2x+1. Each 8-bit channel is (a + b + 1) >> 1 before encoding. With bit 3 also set, source pixel 2x is copied unchanged.
- R11: A trigger with zero destination width or height performs no memory access and sets `done_o` on the next cycle without raising `busy_o`.
- R12: At most one read is outstanding. `rd_req_o` is a single-cycle pulse followed by a wait for `rd_valid_i`. `rd_req_o` and `wr_req_o` are never high together, and no request is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 3 | Config register index |
| cfg_wdata_i | input | 32 | Config write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer finished (sticky) |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | 32 | Read byte address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Write request pulse |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 32 | Write data |

## Verification
The assertions check the memory port discipline on every cycle: single-cycle read pulses, no read and write in the same cycle, and no traffic while idle. They also check that `done_o` is set whenever `busy_o` falls, that the configuration is frozen while busy, and that the column counter stays inside the destination width. Pixel values can only be shown by the bench's scenarios. These cover every source/destination format pair, the flip, the 2:1 average, raw copy with and without halving, the ignored tiling bit, a source pitch wider than the destination, triggers during a run and zero-sized destinations.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  localparam logic [2:0] FMT_RGBA8  = 3'd0;
  localparam logic [2:0] FMT_RGB8   = 3'd1;
  localparam logic [2:0] FMT_RGB565 = 3'd2;
  localparam logic [2:0] FMT_RGB5A1 = 3'd3;
  localparam logic [2:0] FMT_RGBA4  = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_RA, S_WA, S_RB, S_WB, S_WR
  } fbx_state_e;

  localparam logic [2:0] REG_SRC   = 3'd0;
  localparam logic [2:0] REG_DST   = 3'd1;
  localparam logic [2:0] REG_IDIM  = 3'd2;
  localparam logic [2:0] REG_ODIM  = 3'd3;
  localparam logic [2:0] REG_MODE  = 3'd4;
  localparam logic [2:0] REG_START = 3'd5;
endpackage

// File: rtl/fbx_unpack.sv
module fbx_unpack
  import fbx_pkg::*;
(
  input  logic [2:0]  fmt_i,
  input  logic [31:0] px_i,
  output logic [31:0] rgba_o
);
  always_comb begin
    case (fmt_i)
      FMT_RGB8:   rgba_o = {px_i[23:0], 8'hff};
      FMT_RGB565: rgba_o = {px_i[15:11], px_i[15:13], px_i[10:5], px_i[10:9],
                            px_i[4:0], px_i[4:2], 8'hff};
      FMT_RGB5A1: rgba_o = {px_i[15:11], px_i[15:13], px_i[10:6], px_i[10:8],
                            px_i[5:1], px_i[5:3], {8{px_i[0]}}};
      FMT_RGBA4:  rgba_o = {px_i[15:12], px_i[15:12], px_i[11:8], px_i[11:8],
                            px_i[7:4], px_i[7:4], px_i[3:0], px_i[3:0]};
      default:    rgba_o = px_i;
    endcase
  end
endmodule

// File: rtl/fbx_pack.sv
module fbx_pack
  import fbx_pkg::*;
(
  input  logic [2:0]  fmt_i,
  input  logic [31:0] rgba_i,
  output logic [31:0] px_o
);
  always_comb begin
    case (fmt_i)
      FMT_RGB8:   px_o = {8'h00, rgba_i[31:8]};
      FMT_RGB565: px_o = {16'h0, rgba_i[31:27], rgba_i[23:18], rgba_i[15:11]};
      FMT_RGB5A1: px_o = {16'h0, rgba_i[31:27], rgba_i[23:19], rgba_i[15:11], rgba_i[7]};
      FMT_RGBA4:  px_o = {16'h0, rgba_i[31:28], rgba_i[23:20], rgba_i[15:12], rgba_i[7:4]};
      default:    px_o = rgba_i;
    endcase
  end
endmodule

// File: rtl/fbx_ctrl.sv
module fbx_ctrl
  import fbx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DIMW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            flip_i,
  input  logic            half_i,
  input  logic [DIMW-1:0] in_w_i,
  input  logic [DIMW-1:0] out_w_i,
  input  logic [DIMW-1:0] out_h_i,
  input  logic [AW-4:0]   src_base_i,
  input  logic [AW-4:0]   dst_base_i,
  input  logic            rd_valid_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            wr_req_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic            cap0_o,
  output logic            cap1_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int IW = 2 * DIMW + 1;

  fbx_state_e      st_q;
  logic [DIMW-1:0] ox_q, oy_q, iy;
  logic [DIMW:0]   ix;
  logic [IW-1:0]   src_idx, dst_idx;
  logic            done_q, last_col, last_row;

  always_comb begin
    iy = flip_i ? (out_h_i - DIMW'(1) - oy_q) : oy_q;
    ix = half_i ? ({ox_q, 1'b0} + {{DIMW{1'b0}}, (st_q == S_RB)}) : {1'b0, ox_q};
    src_idx = IW'(iy) * IW'(in_w_i) + IW'(ix);
    dst_idx = IW'(oy_q) * IW'(out_w_i) + IW'(ox_q);
  end

  assign rd_addr_o = {src_base_i, 3'b000} + AW'({src_idx, 2'b00});
  assign wr_addr_o = {dst_base_i, 3'b000} + AW'({dst_idx, 2'b00});
  assign rd_req_o  = (st_q == S_RA) || (st_q == S_RB);
  assign wr_req_o  = (st_q == S_WR);
  assign cap0_o    = (st_q == S_WA) && rd_valid_i;
  assign cap1_o    = (st_q == S_WB) && rd_valid_i;
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign last_col  = (ox_q == out_w_i - DIMW'(1));
  assign last_row  = (oy_q == out_h_i - DIMW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ox_q   <= '0;
      oy_q   <= '0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          ox_q <= '0;
          oy_q <= '0;
          if (out_w_i == '0 || out_h_i == '0) done_q <= 1'b1;
          else begin
            done_q <= 1'b0;
            st_q   <= S_RA;
          end
        end
        S_RA: st_q <= S_WA;
        S_WA: if (rd_valid_i) st_q <= half_i ? S_RB : S_WR;
        S_RB: st_q <= S_WB;
        S_WB: if (rd_valid_i) st_q <= S_WR;
        S_WR: begin
          if (last_col) begin
            ox_q <= '0;
            if (last_row) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              oy_q <= oy_q + DIMW'(1);
              st_q <= S_RA;
            end
          end else begin
            ox_q <= ox_q + DIMW'(1);
            st_q <= S_RA;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_rd_wr_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  assert_rd_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || wr_req_o) |-> busy_o);
  assert_done_on_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_col_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ox_q < out_w_i));
endmodule

// File: rtl/fbx_xfer.sv
module fbx_xfer
  import fbx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DIMW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [31:0]   rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o
);
  localparam int NCH = 4;

  logic [AW-4:0]   src_q, dst_q;
  logic [DIMW-1:0] in_w_q, out_w_q, out_h_q;
  logic            flip_q, raw_q, half_q;
  logic [2:0]      ifmt_q, ofmt_q;
  logic [31:0]     p0_q, p1_q, u0, u1, avg, mix, packed_px;
  logic            cfg_ok, start, cap0, cap1;

  assign cfg_ok = cfg_we_i && !busy_o;
  assign start  = cfg_ok && (cfg_addr_i == REG_START) && cfg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0;
      in_w_q <= '0; out_w_q <= '0; out_h_q <= '0;
      flip_q <= 1'b0; raw_q <= 1'b0; half_q <= 1'b0;
      ifmt_q <= '0; ofmt_q <= '0;
    end else if (cfg_ok) begin
      case (cfg_addr_i)
        REG_SRC:  src_q  <= cfg_wdata_i[AW-4:0];
        REG_DST:  dst_q  <= cfg_wdata_i[AW-4:0];
        REG_IDIM: in_w_q <= cfg_wdata_i[DIMW-1:0];
        REG_ODIM: begin
          out_w_q <= cfg_wdata_i[DIMW-1:0];
          out_h_q <= cfg_wdata_i[16 +: DIMW];
        end
        REG_MODE: begin
          flip_q <= cfg_wdata_i[0];
          raw_q  <= cfg_wdata_i[3];
          ifmt_q <= cfg_wdata_i[10:8];
          ofmt_q <= cfg_wdata_i[14:12];
          half_q <= cfg_wdata_i[24];
        end
        default: ;
      endcase
    end
  end

  assert_cfg_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cfg_we_i) |=> $stable({src_q, dst_q, in_w_q, out_w_q, out_h_q,
                                      flip_q, raw_q, half_q, ifmt_q, ofmt_q}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_q <= '0;
      p1_q <= '0;
    end else begin
      if (cap0) p0_q <= rd_data_i;
      if (cap1) p1_q <= rd_data_i;
    end
  end

  fbx_unpack u_unp0 (.fmt_i(ifmt_q), .px_i(p0_q), .rgba_o(u0));
  fbx_unpack u_unp1 (.fmt_i(ifmt_q), .px_i(p1_q), .rgba_o(u1));

  for (genvar c = 0; c < NCH; c++) begin : g_avg
    logic [8:0] sum;
    assign sum = {1'b0, u0[c*8 +: 8]} + {1'b0, u1[c*8 +: 8]} + 9'd1;
    assign avg[c*8 +: 8] = 8'(sum >> 1);
  end

  assign mix = half_q ? avg : u0;

  fbx_pack u_pack (.fmt_i(ofmt_q), .rgba_i(mix), .px_o(packed_px));

  assign wr_data_o = raw_q ? p0_q : packed_px;

  fbx_ctrl #(.AW(AW), .DIMW(DIMW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .flip_i     (flip_q),
    .half_i     (half_q),
    .in_w_i     (in_w_q),
    .out_w_i    (out_w_q),
    .out_h_i    (out_h_q),
    .src_base_i (src_q),
    .dst_base_i (dst_q),
    .rd_valid_i (rd_valid_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .wr_req_o   (wr_req_o),
    .wr_addr_o  (wr_addr_o),
    .cap0_o     (cap0),
    .cap1_o     (cap1),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/tb_fbx_xfer.sv
module tb_fbx_xfer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        busy, done, rd_req, rd_valid, wr_req;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;

  fbx_xfer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .busy_o(busy), .done_o(done),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  localparam int DST_W = 256;  // dst word index, byte 0x400
  localparam int ALT_W = 400;  // alternate dst word index, byte 0x640

  logic [31:0] mem [0:511];
  int rd_cnt = 0, wr_cnt = 0;
  int total = 0, bad = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_valid <= rd_req;
    if (rd_req) begin
      rd_data <= mem[rd_addr[10:2]];
      rd_cnt <= rd_cnt + 1;
    end
    if (wr_req) begin
      mem[wr_addr[10:2]] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    total++; bad++;
    $display("FAIL watchdog got=%0d exp=<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] unp(input int f, input logic [31:0] p);
    int r, g, b, a;
    case (f)
      1: begin r = p[23:16]; g = p[15:8]; b = p[7:0]; a = 255; end
      2: begin r = (p >> 11) & 31; g = (p >> 5) & 63; b = p & 31;
               r = r*8 + r/4; g = g*4 + g/16; b = b*8 + b/4; a = 255; end
      3: begin r = (p >> 11) & 31; g = (p >> 6) & 31; b = (p >> 1) & 31;
               r = r*8 + r/4; g = g*8 + g/4; b = b*8 + b/4; a = (p & 1) * 255; end
      4: begin r = ((p >> 12) & 15) * 17; g = ((p >> 8) & 15) * 17;
               b = ((p >> 4) & 15) * 17; a = (p & 15) * 17; end
      default: begin r = p[31:24]; g = p[23:16]; b = p[15:8]; a = p[7:0]; end
    endcase
    return 32'(r*16777216 + g*65536 + b*256 + a);
  endfunction

  function automatic logic [31:0] pck(input int f, input logic [31:0] c);
    int r, g, b, a;
    r = c[31:24]; g = c[23:16]; b = c[15:8]; a = c[7:0];
    case (f)
      1: return 32'(r*65536 + g*256 + b);
      2: return 32'((r/8)*2048 + (g/4)*32 + b/8);
      3: return 32'((r/8)*2048 + (g/8)*64 + (b/8)*2 + a/128);
      4: return 32'((r/16)*4096 + (g/16)*256 + (b/16)*16 + a/16);
      default: return c;
    endcase
  endfunction

  function automatic logic [31:0] avg2(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] o;
    for (int c = 0; c < 4; c++) o[c*8 +: 8] = 8'((int'(x[c*8 +: 8]) + int'(y[c*8 +: 8]) + 1) / 2);
    return o;
  endfunction

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (busy) begin total++; bad++; $display("FAIL %s got=busy exp=idle", req); end
  endtask

  task automatic clear_dst();
    for (int i = 0; i < 128; i++) begin mem[DST_W + i] = 0; mem[ALT_W + i - 16] = 0; end
  endtask

  task automatic setup(input logic [31:0] mode, input int iw, input int ow, input int oh);
    cfg(3'd0, 32'h0);
    cfg(3'd1, 32'(DST_W * 4 / 8));
    cfg(3'd2, 32'(oh * 65536 + iw));
    cfg(3'd3, 32'(oh * 65536 + ow));
    cfg(3'd4, mode);
  endtask

  task automatic verify(input logic [31:0] mode, input int iw, input int ow, input int oh,
                        input int rd0, input int wr0, input string req);
    int ifm, ofm, iy, ix;
    logic [31:0] a, b, e;
    bit flip, raw, half;
    flip = mode[0]; raw = mode[3]; half = mode[24];
    ifm = int'(mode[10:8]); ofm = int'(mode[14:12]);
    for (int y = 0; y < oh; y++)
      for (int x = 0; x < ow; x++) begin
        iy = flip ? oh - 1 - y : y;
        ix = half ? 2 * x : x;
        a = mem[iy * iw + ix];
        b = mem[iy * iw + ix + 1];
        if (raw) e = a;
        else if (half) e = pck(ofm, avg2(unp(ifm, a), unp(ifm, b)));
        else e = pck(ofm, unp(ifm, a));
        chk(req, mem[DST_W + y * ow + x], e);
      end
    chk({req, " R1 no write past frame"}, mem[DST_W + ow * oh], 32'h0);
    chk({req, " R12 read count"}, 32'(rd_cnt - rd0), 32'(ow * oh * (half ? 2 : 1)));
    chk({req, " R12 write count"}, 32'(wr_cnt - wr0), 32'(ow * oh));
    chk({req, " R3 done"}, {31'b0, done}, 32'd1);
  endtask

  task automatic run(input logic [31:0] mode, input int iw, input int ow, input int oh,
                     input string req);
    int rd0, wr0;
    clear_dst();
    setup(mode, iw, ow, oh);
    rd0 = rd_cnt; wr0 = wr_cnt;
    cfg(3'd5, 32'h1);
    chk({req, " R3 busy after start"}, {31'b0, busy}, 32'd1);
    chk({req, " R3 done cleared"}, {31'b0, done}, 32'd0);
    wait_idle(req);
    @(negedge clk);
    verify(mode, iw, ow, oh, rd0, wr0, req);
  endtask

  initial begin
    int rd0, wr0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rd_valid = 1'b0; rd_data = '0;
    for (int i = 0; i < 512; i++) mem[i] = 0;
    for (int i = 0; i < 128; i++) mem[i] = 32'(i) * 32'h9E3779B1 + 32'h01234567;
    mem[5] = 32'hFFFFFFFF; mem[6] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R3 reset busy", {31'b0, busy}, 32'd0);
    chk("R3 reset done", {31'b0, done}, 32'd0);
    chk("R12 reset rd_req", {31'b0, rd_req}, 32'd0);
    chk("R12 reset wr_req", {31'b0, wr_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R7: every source/destination code pair, codes 5..7 included
    for (int fi = 0; fi < 8; fi++)
      for (int fo = 0; fo < 8; fo++)
        run(32'(fi * 256 + fo * 4096), 4, 4, 3, "R5 R6 R7 convert");

    run(32'h0000_0000, 6, 4, 3, "R2 wide pitch");
    run(32'h0000_1201, 4, 4, 3, "R8 flip");
    run(32'h0000_0202, 4, 4, 3, "R9 tiling ignored");
    run(32'h0000_240B, 4, 4, 3, "R9 raw copy");
    run(32'h0000_240A, 6, 3, 2, "R9 raw over tiling");
    for (int f = 0; f < 5; f++)
      run(32'h0100_0000 + 32'(f * 256 + ((f + 2) % 5) * 4096), 8, 4, 3, "R10 half average");
    run(32'h0100_0301, 8, 4, 3, "R10 half flip");
    run(32'h0100_2408, 8, 4, 3, "R10 raw half even pixel");

    // R4: config and trigger writes during a run are ignored
    clear_dst();
    setup(32'h0000_0000, 4, 4, 3);
    rd0 = rd_cnt; wr0 = wr_cnt;
    cfg(3'd5, 32'h1);
    cfg(3'd1, 32'(ALT_W * 4 / 8));
    cfg(3'd4, 32'h0100_1201);
    cfg(3'd3, 32'h0001_0001);
    cfg(3'd5, 32'h1);
    wait_idle("R4");
    repeat (20) @(negedge clk);
    chk("R4 no restart", {31'b0, busy}, 32'd0);
    verify(32'h0000_0000, 4, 4, 3, rd0, wr0, "R4 ignored writes");
    chk("R4 alt dst untouched", mem[ALT_W], 32'h0);

    // R11: zero destination size
    for (int z = 0; z < 2; z++) begin
      clear_dst();
      setup(32'h0, 4, z == 0 ? 0 : 4, z == 0 ? 3 : 0);
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'h1;
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R11 zero no busy", {31'b0, busy}, 32'd0);
      chk("R11 zero done", {31'b0, done}, 32'd1);
      repeat (5) @(negedge clk);
      chk("R11 zero no reads", 32'(rd_cnt - rd0), 32'd0);
      chk("R11 zero no writes", 32'(wr_cnt - wr0), 32'd0);
      chk("R11 zero dst untouched", mem[DST_W], 32'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule